// File: doc/BRIEF.md
# Two-Level Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. A short global history of the most recent resolved branch outcomes is joined with a few low bits of the fetch address. The result selects one 2-bit entry in a pattern table. The prediction appears combinationally in the same cycle as the fetch address. The block also returns the history value it used, so the pipeline can carry that snapshot alongside the branch.

When the branch resolves in execute, the pipeline sends back the branch address, the real outcome and the carried snapshot. The block then does two things on the next clock edge:
- It trains the entry that made the prediction.
- It shifts the outcome into the global history.

Each entry is not a saturating counter. It is a small state machine that holds the predicted direction and whether the most recent prediction from that entry was wrong. Its direction changes only after two misses in a row.

Top module: `gh_dir_predictor`

## Requirements
- R1: After a synchronous active-high reset, every table entry is in state 2'b00 (predict not-taken, last prediction right) and the global history is zero, so `pred_taken` is 0 and `pred_hist` is 0.
- R2: The entry used for a prediction has index {history, fetch_pc[IDX_W+1:2]}, with the history in the upper bits. Address bits [1:0] and bits above IDX_W+1 have no effect on the prediction.
- R3: `pred_taken` equals bit 1 (the direction bit, 1 = taken) of the selected entry in the same cycle. `pred_hist` equals the current global history.
- R4: An entry's state is {dir, miss}. On an update with outcome equal to dir, the state becomes {dir, 0}. On a mismatch while miss is 0, it becomes {dir, 1}. On a mismatch while miss is 1, it becomes {~dir, 0}.
- R5: The direction bit of an entry changes only on the second consecutive mispredicting update of that entry. A single miss leaves the prediction unchanged.
- R6: On each cycle with `upd_valid` high, the history shifts left by one and `upd_taken` enters bit 0. With `upd_valid` low, the history holds its value.
- R7: An update trains the entry at index {upd_hist, upd_pc[IDX_W+1:2]}. It uses the supplied snapshot, not the current history.
- R8: When a prediction and an update select the same entry in one cycle, the prediction reflects the entry's state before the update. The new state is visible from the next cycle.
- R9: While `upd_valid` is low, the values on `upd_pc`, `upd_taken` and `upd_hist` have no effect on any table entry or on the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Address being fetched |
| pred_taken | output | 1 | Predicted direction for fetch_pc (1 = taken) |
| pred_hist | output | HIST_W | History value used for this prediction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| upd_hist | input | HIST_W | History snapshot taken when the branch was predicted |

## Verification
A lookup and a resolved-branch update can land on the same table entry in one clock cycle. This is the collision case.

The bench provokes it in two ways:
- A directed step drives the same address on both ports and sets the snapshot equal to the live history.
- A long pseudo-random phase draws addresses from a small pool, so collisions recur often.

A scoreboard model is updated only after each cycle's expected prediction has been taken from it. Any prediction that reveals the freshly written state is therefore reported against R8. Lookup and update also coincide on the history register, since `pred_hist` must still show the pre-shift value.

// File: rtl/gh_pred_pkg.sv
package gh_pred_pkg;

  // One table entry: predicted direction plus "last prediction missed".
  typedef struct packed {
    logic dir;
    logic miss;
  } gh_state_t;

  localparam gh_state_t GH_STATE_RESET = '{dir: 1'b0, miss: 1'b0};

  // Hysteresis training rule: direction flips on the second miss in a row.
  function automatic gh_state_t gh_train(gh_state_t cur, logic taken);
    gh_state_t nxt;
    if (taken == cur.dir) begin
      nxt.dir  = cur.dir;
      nxt.miss = 1'b0;
    end else if (!cur.miss) begin
      nxt.dir  = cur.dir;
      nxt.miss = 1'b1;
    end else begin
      nxt.dir  = ~cur.dir;
      nxt.miss = 1'b0;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/gh_hist_reg.sv
module gh_hist_reg #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_q
);

  generate
    if (HIST_W == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= bit_in;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], bit_in};
      end
    end
  endgenerate

  // Newest outcome lands in bit 0 (R6)
  assert_hist_newest_R6: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist_q[0] == $past(bit_in));

  // Without a resolved branch the history is frozen (R6, R9)
  assert_hist_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/gh_pht.sv
module gh_pht #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [DATA_W-1:0] look_data,
  input  logic [ADDR_W-1:0] train_addr,
  output logic [DATA_W-1:0] train_data,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Two asynchronous read ports: lookup and read-modify-write for training
  assign look_data  = mem[look_addr];
  assign train_data = mem[train_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[train_addr] <= wr_data;
    end
  end

  // A write lands in the entry it targeted (R7)
  assert_pht_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(train_addr)] == $past(wr_data));

  // Without a write the looked-up entry keeps its contents (R9)
  assert_pht_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> mem[$past(look_addr)] == $past(look_data));

endmodule

// File: rtl/gh_fsm_next.sv
module gh_fsm_next
  import gh_pred_pkg::*;
(
  input  gh_state_t cur,
  input  logic      taken,
  output gh_state_t nxt
);

  assign nxt = gh_train(cur, taken);

endmodule

// File: rtl/gh_dir_predictor.sv
module gh_dir_predictor
  import gh_pred_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist
);

  localparam int TAB_AW = IDX_W + HIST_W;
  localparam int PC_LO  = 2;
  localparam int PC_HI  = IDX_W + PC_LO - 1;

  logic [HIST_W-1:0] ghist;
  logic [TAB_AW-1:0] look_idx;
  logic [TAB_AW-1:0] train_idx;
  gh_state_t         look_st;
  gh_state_t         train_st;
  gh_state_t         train_nxt;

  assign look_idx  = {ghist,    fetch_pc[PC_HI:PC_LO]};
  assign train_idx = {upd_hist, upd_pc[PC_HI:PC_LO]};

  gh_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (upd_valid),
    .bit_in   (upd_taken),
    .hist_q   (ghist)
  );

  gh_pht #(.ADDR_W(TAB_AW), .DATA_W($bits(gh_state_t))) u_pht (
    .clk        (clk),
    .rst        (rst),
    .look_addr  (look_idx),
    .look_data  (look_st),
    .train_addr (train_idx),
    .train_data (train_st),
    .wr_en      (upd_valid),
    .wr_data    (train_nxt)
  );

  gh_fsm_next u_fsm (
    .cur   (train_st),
    .taken (upd_taken),
    .nxt   (train_nxt)
  );

  assign pred_taken = look_st.dir;
  assign pred_hist  = ghist;

  // First cycle after reset: not-taken with clear history (R1)
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pred_taken && pred_hist == '0));

  // Direction only changes after a prior miss plus another miss (R5)
  assert_flip_needs_two_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && train_nxt.dir != train_st.dir) |->
      (train_st.miss && upd_taken != train_st.dir));

  // A hit always clears the miss flag (R4)
  assert_hit_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken == train_st.dir) |-> !train_nxt.miss);

endmodule

// File: tb/gh_dir_predictor_bench.sv
module gh_dir_predictor_bench;

  localparam int PC_W   = 32;
  localparam int IDX_W  = 6;
  localparam int HIST_W = 2;
  localparam int N      = 1 << (IDX_W + HIST_W);

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic              rst = 1'b1;
  logic [PC_W-1:0]   fetch_pc = '0;
  logic              pred_taken;
  logic [HIST_W-1:0] pred_hist;
  logic              upd_valid = 1'b0;
  logic [PC_W-1:0]   upd_pc = '0;
  logic              upd_taken = 1'b0;
  logic [HIST_W-1:0] upd_hist = '0;

  gh_dir_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_gh_dir_predictor (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Scoreboard queues
  string             q_req[$];
  logic              q_tk[$];
  logic [HIST_W-1:0] q_h[$];

  // Reference model built from the requirements
  logic [1:0]        m_tab [N];
  logic [HIST_W-1:0] m_hist;

  function automatic logic [IDX_W+HIST_W-1:0] mk(logic [HIST_W-1:0] h, logic [PC_W-1:0] pc);
    return {h, pc[IDX_W+1:2]};
  endfunction

  task automatic step(string req, logic [PC_W-1:0] pc, logic uv,
                      logic [PC_W-1:0] upc, logic ut, logic [HIST_W-1:0] uh);
    logic [1:0] s;
    @(posedge clk); #1;
    fetch_pc = pc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_hist = uh;
    q_req.push_back(req);
    q_tk.push_back(m_tab[mk(m_hist, pc)][1]);
    q_h.push_back(m_hist);
    if (uv) begin
      s = m_tab[mk(uh, upc)];
      if (ut == s[1])      s = {s[1], 1'b0};
      else if (!s[0])      s = {s[1], 1'b1};
      else                 s = {~s[1], 1'b0};
      m_tab[mk(uh, upc)] = s;
      m_hist = {m_hist[HIST_W-2:0], ut};
    end
  endtask

  task automatic look(string req, logic [PC_W-1:0] pc);
    step(req, pc, 1'b0, 32'hDEAD_BEE0, 1'b1, 2'b11);
  endtask

  // Two not-taken updates on an unrelated entry bring history back to zero
  task automatic zero_hist();
    step("R6", 32'h0000_0F00, 1'b1, 32'h0000_0F00, 1'b0, 2'b11);
    step("R6", 32'h0000_0F00, 1'b1, 32'h0000_0F00, 1'b0, 2'b11);
  endtask

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (q_req.size() > 0) begin
      string r; logic et; logic [HIST_W-1:0] eh;
      r = q_req.pop_front(); et = q_tk.pop_front(); eh = q_h.pop_front();
      checks++;
      if (pred_taken !== et) begin
        errors++;
        $display("FAIL %s pred_taken actual=%0b expected=%0b", r, pred_taken, et);
      end
      checks++;
      if (pred_hist !== eh) begin
        errors++;
        $display("FAIL %s pred_hist actual=%0h expected=%0h", r, pred_hist, eh);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [PC_W-1:0] PA = 32'h0000_0104;
  localparam logic [PC_W-1:0] PB = 32'h0000_0208;

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) m_tab[i] = 2'b00;
    m_hist = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    look("R1", 32'h0000_0000);
    look("R1", PA);
    look("R1", 32'hFFFF_FFFC);

    // R4/R5: one miss keeps the direction, second miss flips it
    step("R4", PA, 1'b1, PA, 1'b1, 2'b00);
    zero_hist();
    look("R5 single miss no flip", PA);
    step("R4", PA, 1'b1, PA, 1'b1, 2'b00);
    zero_hist();
    look("R4 flip after two misses", PA);
    look("R3", PA);

    // R2: ignored address bits
    look("R2 low bits", PA + 32'd1);
    look("R2 low bits", PA + 32'd3);
    look("R2 high bits", PA + (32'd1 << (IDX_W + 2)));

    // R4: hit after miss clears the flag, then a single miss does not flip
    step("R4", PA, 1'b1, PA, 1'b0, 2'b00);
    step("R4", PA, 1'b1, PA, 1'b1, 2'b00);
    step("R4", PA, 1'b1, PA, 1'b0, 2'b00);
    zero_hist();
    look("R4 hit clears miss", PA);

    // R7: train through a snapshot different from the live history
    step("R7", PB, 1'b1, PB, 1'b1, 2'b10);
    step("R7", PB, 1'b1, PB, 1'b1, 2'b10);
    step("R6", PB, 1'b1, 32'h0000_0F00, 1'b1, 2'b00);
    step("R6", PB, 1'b1, 32'h0000_0F00, 1'b0, 2'b00);
    look("R7 snapshot entry", PB);
    zero_hist();
    look("R7 live entry untouched", PB);

    // R9: idle update fields do nothing
    for (int i = 0; i < 6; i++) step("R9", PA, 1'b0, PA, i[0], i[1:0]);
    look("R9", PA);

    // R8: same entry predicted and updated in one cycle
    zero_hist();
    step("R8 collision", PA, 1'b1, PA, 1'b1, 2'b00);
    step("R8 collision", PA, 1'b1, PA, 1'b1, 2'b01);
    look("R8 after", PA);

    // Random mix with frequent collisions
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      logic [PC_W-1:0] fp, up;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fp = {20'(lfsr), 10'd0, 2'(lfsr[3:2])} | {27'd0, lfsr[6:4], 2'b00};
      up = lfsr[7] ? fp : {27'd0, lfsr[10:8], 2'b00};
      step("R8 R4 R6 random", fp, lfsr[11] | lfsr[12], up, lfsr[13] ^ lfsr[1],
           lfsr[14] ? m_hist : lfsr[15:14]);
    end

    @(posedge clk); #1 upd_valid = 1'b0;
    @(negedge clk); #1;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule